// File: doc/BRIEF.md
# Configuration Header Ratio Selector

This block sits beside a configuration word stream and watches the header words go past without holding or forwarding them. It takes two flags from fixed word positions. Word 69 carries the encryption flag and word 229 carries the compression flag. From those two flags and the selected configuration width (16 or 32 bits), it produces the clock-to-data ratio code and the width select that the parallel loader uses.

A stream that ends before word 229 arrives is too short. The block flags it as an error and never produces a valid ratio. A separate override input forces the ratio to x1 for as long as it is held, which lets a later sync stage clock all-ones words at a one-to-one rate. When the override is released, the ratio that was computed returns unchanged.

Top module: `hdr_ratio_sel`

## Requirements
- R1: After reset, `ratio_vld` and `short_err` are 0, `ratio_code` is 0 (x1) and `wide_out` is 0.
- R2: The encryption flag is set when bits [3:2] of the word with index 69 are not both zero.
- R3: The compression flag is set when bit 1 of the word with index 229 is zero (the bit is active-low).
- R4: When `wide_sel` is 0 (16-bit), the ratio codes are as follows, with x1=0, x2=1, x4=2 and x8=3:
  - neither flag gives x1 (0);
  - encryption alone gives x2 (1);
  - compression, with or without encryption, gives x4 (2).
- R5: When `wide_sel` is 1 (32-bit), the ratio codes are as follows:
  - neither flag gives x1 (0);
  - encryption alone gives x4 (2);
  - compression gives x8 (3).
  - Code 3 never appears while `wide_out` is 0.
- R6: `ratio_vld` rises in the cycle after the clock edge that accepts word 229. `wide_out` reports `wide_sel` as sampled with that word.
- R7: If `hdr_end` is accepted before word 229, then in the next cycle `short_err` is 1, `ratio_vld` stays 0 and `ratio_code` stays 0.
- R8: If word 229 and `hdr_end` arrive in the same cycle, the header counts as complete: `ratio_vld` becomes 1 and `short_err` stays 0.
- R9: Once `ratio_vld` or `short_err` is set, further words and `hdr_end` are ignored, and all outputs hold until `start`.
- R10: `start` clears the flags, `ratio_vld`, `short_err` and `wide_out` on the next edge. A word presented in the same cycle as `start` is dropped.
- R11: While `force_x1` is 1, `ratio_code` reads 0 in that same cycle. When `force_x1` drops, the previous code is restored. `ratio_vld` and `wide_out` are unaffected.
- R12: A word with `word_vld` at 0 is ignored, whatever its index and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | A new stream begins; clears all captured state |
| word_vld | input | 1 | Qualifies `word_idx` and `word_data` |
| word_idx | input | IDX_W | Position of the current word in the stream |
| word_data | input | DATA_W | Current stream word |
| wide_sel | input | 1 | 1 selects 32-bit configuration width, 0 selects 16-bit |
| hdr_end | input | 1 | The stream has ended |
| force_x1 | input | 1 | Overrides the ratio output to x1 while high |
| ratio_code | output | 2 | Ratio code: 0=x1, 1=x2, 2=x4, 3=x8 |
| wide_out | output | 1 | Width select latched with word 229 |
| ratio_vld | output | 1 | Ratio code is valid |
| short_err | output | 1 | Stream ended before word 229 |

## Verification
Word 229 and the end-of-stream indication can land in the same cycle. At that point the block must choose between completing the header and flagging it as too short. The bench provokes this by driving `hdr_end` alongside the exact 230th word. The behavioural model, which gives the word priority, then expects `ratio_vld` high with `short_err` low. A second collision, `start` arriving together with word 229, is judged the same way: the bench expects nothing to be captured.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;
   typedef enum logic [1:0] {
      RAT_X1 = 2'd0,
      RAT_X2 = 2'd1,
      RAT_X4 = 2'd2,
      RAT_X8 = 2'd3
   } ratio_t;
endpackage

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 16,
   parameter int ENC_IDX = 69,
   parameter int CMP_IDX = 229,
   parameter int ENC_LSB = 2,
   parameter int CMP_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              word_vld,
   input  logic [IDX_W-1:0]  word_idx,
   input  logic [DATA_W-1:0] word_data,
   input  logic              wide_sel,
   input  logic              hdr_end,
   output logic              enc_o,
   output logic              cmp_o,
   output logic              wide_o,
   output logic              vld_o,
   output logic              err_o
);
   localparam logic [IDX_W-1:0] ENC_POS = IDX_W'(ENC_IDX);
   localparam logic [IDX_W-1:0] CMP_POS = IDX_W'(CMP_IDX);

   logic enc_q, cmp_q, wide_q, vld_q, err_q;
   logic open_w, hit_enc, hit_cmp;

   assign open_w  = !vld_q && !err_q;
   assign hit_enc = open_w && word_vld && (word_idx == ENC_POS);
   assign hit_cmp = open_w && word_vld && (word_idx == CMP_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enc_q  <= 1'b0;
         cmp_q  <= 1'b0;
         wide_q <= 1'b0;
         vld_q  <= 1'b0;
         err_q  <= 1'b0;
      end else if (start) begin
         enc_q  <= 1'b0;
         cmp_q  <= 1'b0;
         wide_q <= 1'b0;
         vld_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (hit_enc)
            enc_q <= |word_data[ENC_LSB+1:ENC_LSB];
         if (hit_cmp) begin
            cmp_q  <= ~word_data[CMP_BIT];
            wide_q <= wide_sel;
            vld_q  <= 1'b1;
         end else if (open_w && hdr_end) begin
            err_q <= 1'b1;
         end
      end
   end

   assign enc_o  = enc_q;
   assign cmp_o  = cmp_q;
   assign wide_o = wide_q;
   assign vld_o  = vld_q;
   assign err_o  = err_q;

   AST_VLD_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(vld_q && err_q)); // R8
   AST_ERR_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(hdr_end)); // R7
   AST_VLD_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_q) |-> $past(word_vld && word_idx == CMP_POS)); // R6
   AST_HOLD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && !start) |=> (vld_q && $stable(cmp_q) && $stable(enc_q) && $stable(wide_q))); // R9
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!vld_q && !err_q && !wide_q)); // R10
endmodule

// File: rtl/hdr_ratio_map.sv
module hdr_ratio_map
   import hdr_ratio_pkg::*;
(
   input  logic   enc,
   input  logic   cmp,
   input  logic   wide,
   input  logic   vld,
   output ratio_t ratio
);
   ratio_t base;

   always_comb begin
      if (cmp)
         base = RAT_X4;
      else if (enc)
         base = RAT_X2;
      else
         base = RAT_X1;

      if (!vld)
         ratio = RAT_X1;
      else if (wide && base != RAT_X1)
         ratio = ratio_t'(base + 2'd1);
      else
         ratio = base;
   end
endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
   import hdr_ratio_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 16,
   parameter int ENC_IDX = 69,
   parameter int CMP_IDX = 229,
   parameter int ENC_LSB = 2,
   parameter int CMP_BIT = 1,
   parameter bit OVR_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              word_vld,
   input  logic [IDX_W-1:0]  word_idx,
   input  logic [DATA_W-1:0] word_data,
   input  logic              wide_sel,
   input  logic              hdr_end,
   input  logic              force_x1,
   output logic [1:0]        ratio_code,
   output logic              wide_out,
   output logic              ratio_vld,
   output logic              short_err
);
   generate
      if (CMP_IDX <= ENC_IDX)
         $error("compression word must follow encryption word");
      if (CMP_IDX >= (1 << IDX_W))
         $error("IDX_W too narrow for CMP_IDX");
      if (ENC_LSB + 1 >= DATA_W || CMP_BIT >= DATA_W)
         $error("flag bit positions exceed DATA_W");
   endgenerate

   logic   enc_w, cmp_w, wide_w, vld_w, err_w;
   ratio_t ratio_w;

   hdr_flag_capture #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .ENC_IDX(ENC_IDX),
      .CMP_IDX(CMP_IDX),
      .ENC_LSB(ENC_LSB),
      .CMP_BIT(CMP_BIT)
   ) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .word_vld (word_vld),
      .word_idx (word_idx),
      .word_data(word_data),
      .wide_sel (wide_sel),
      .hdr_end  (hdr_end),
      .enc_o    (enc_w),
      .cmp_o    (cmp_w),
      .wide_o   (wide_w),
      .vld_o    (vld_w),
      .err_o    (err_w)
   );

   hdr_ratio_map u_map (
      .enc  (enc_w),
      .cmp  (cmp_w),
      .wide (wide_w),
      .vld  (vld_w),
      .ratio(ratio_w)
   );

   generate
      if (OVR_REG) begin : g_ovr_reg
         logic [1:0] code_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               code_q <= 2'd0;
            else
               code_q <= force_x1 ? 2'(RAT_X1) : 2'(ratio_w);
         end
         assign ratio_code = code_q;
      end else begin : g_ovr_comb
         assign ratio_code = force_x1 ? 2'(RAT_X1) : 2'(ratio_w);
      end
   endgenerate

   assign wide_out  = wide_w;
   assign ratio_vld = vld_w;
   assign short_err = err_w;

   AST_X8_NEEDS_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_code == 2'(RAT_X8)) |-> wide_out); // R5
   AST_ERR_RATIO_X1: assert property (@(posedge clk) disable iff (!rst_n)
      short_err |-> (ratio_code == 2'(RAT_X1))); // R7
endmodule

// File: tb/hdr_ratio_sel_test.sv
`timescale 1ns/1ps
module hdr_ratio_sel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        word_vld = 1'b0;
   logic [15:0] word_idx = '0;
   logic [31:0] word_data = '0;
   logic        wide_sel = 1'b0;
   logic        hdr_end = 1'b0;
   logic        force_x1 = 1'b0;
   logic [1:0]  ratio_code;
   logic        wide_out, ratio_vld, short_err;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   hdr_ratio_sel uut (
      .clk(clk), .rst_n(rst_n), .start(start), .word_vld(word_vld),
      .word_idx(word_idx), .word_data(word_data), .wide_sel(wide_sel),
      .hdr_end(hdr_end), .force_x1(force_x1), .ratio_code(ratio_code),
      .wide_out(wide_out), .ratio_vld(ratio_vld), .short_err(short_err)
   );

   // behavioural reference model
   bit m_enc, m_cmp, m_wide, m_vld, m_err;

   function automatic int model_ratio();
      int r;
      if (!m_vld) r = 0;
      else if (m_cmp) r = m_wide ? 3 : 2;
      else if (m_enc) r = m_wide ? 2 : 1;
      else r = 0;
      if (force_x1) r = 0;
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n || start) begin
         m_enc = 0; m_cmp = 0; m_wide = 0; m_vld = 0; m_err = 0;
      end else if (!m_vld && !m_err) begin
         if (word_vld && word_idx == 16'd69) m_enc = (word_data[3:2] != 2'b00);
         if (word_vld && word_idx == 16'd229) begin
            m_cmp = (word_data[1] == 1'b0);
            m_wide = wide_sel;
            m_vld = 1;
         end else if (hdr_end) m_err = 1;
      end
      #2;
      if (rst_n && !done) begin
         checks++;
         if (int'(ratio_code) != model_ratio()) begin
            errors++;
            $display("FAIL R4/R5 model ratio_code act=%0d exp=%0d", ratio_code, model_ratio());
         end
         checks++;
         if (ratio_vld != m_vld || wide_out != m_wide) begin
            errors++;
            $display("FAIL R6 model vld/wide act=%0b/%0b exp=%0b/%0b", ratio_vld, wide_out, m_vld, m_wide);
         end
         checks++;
         if (short_err != m_err) begin
            errors++;
            $display("FAIL R7 model short_err act=%0b exp=%0b", short_err, m_err);
         end
      end
   end

   task automatic chk(string req, int exp_r, bit exp_v, bit exp_e, bit exp_w);
      checks++;
      if (int'(ratio_code) != exp_r || ratio_vld != exp_v || short_err != exp_e || wide_out != exp_w) begin
         errors++;
         $display("FAIL %s act r=%0d v=%0b e=%0b w=%0b exp r=%0d v=%0b e=%0b w=%0b",
                  req, ratio_code, ratio_vld, short_err, wide_out, exp_r, exp_v, exp_e, exp_w);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      start = 0; word_vld = 0; hdr_end = 0;
   endtask

   // send a stream of n words; end_mode 0: hdr_end on a later cycle, 1: with last word
   task automatic stream(int n, bit [1:0] enc_bits, bit cmp_bit, bit wide, bit end_mode);
      @(negedge clk);
      start = 1; word_vld = 0; hdr_end = 0;
      @(negedge clk);
      start = 0;
      wide_sel = wide;
      for (int i = 0; i < n; i++) begin
         word_vld = 1;
         word_idx = 16'(i);
         word_data = 32'(i * 32'h01010101);
         if (i == 69) word_data = {28'hABCDE00, enc_bits, 2'b01};
         if (i == 229) word_data = {29'h1234567, 1'b0, cmp_bit, 1'b1};
         hdr_end = end_mode && (i == n - 1);
         if (i == 100) begin
            // R12: a gap cycle with a decoy index and enc bits set
            word_vld = 0; word_idx = 16'd69; word_data = 32'hFFFF_FFFF;
            @(negedge clk);
            word_vld = 1; word_idx = 16'(i); word_data = 32'(i * 32'h01010101);
         end
         @(negedge clk);
      end
      word_vld = 0; hdr_end = 0;
      if (!end_mode) begin
         hdr_end = 1;
         @(negedge clk);
         hdr_end = 0;
      end
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", 0, 0, 0, 0);
      rst_n = 1;
      idle();
      chk("R1 after release", 0, 0, 0, 0);

      stream(240, 2'b00, 1'b1, 1'b0, 1'b0); chk("R4 16b none", 0, 1, 0, 0);
      stream(240, 2'b01, 1'b1, 1'b0, 1'b0); chk("R2 R4 16b enc", 1, 1, 0, 0);
      stream(240, 2'b00, 1'b0, 1'b0, 1'b0); chk("R3 R4 16b cmp", 2, 1, 0, 0);
      stream(240, 2'b10, 1'b0, 1'b0, 1'b0); chk("R4 16b both", 2, 1, 0, 0);
      stream(240, 2'b00, 1'b1, 1'b1, 1'b0); chk("R5 32b none", 0, 1, 0, 1);
      stream(240, 2'b11, 1'b1, 1'b1, 1'b0); chk("R2 R5 32b enc", 2, 1, 0, 1);
      stream(240, 2'b00, 1'b0, 1'b1, 1'b0); chk("R3 R5 32b cmp", 3, 1, 0, 1);

      // R9: late words and hdr_end after valid are ignored
      @(negedge clk);
      word_vld = 1; word_idx = 16'd229; word_data = 32'h0000_0002; wide_sel = 0; hdr_end = 1;
      @(negedge clk);
      word_vld = 0; hdr_end = 0;
      @(negedge clk);
      chk("R9 hold after valid", 3, 1, 0, 1);

      // R11: force x1 and restore
      force_x1 = 1;
      #1 chk("R11 forced x1", 0, 1, 0, 1);
      @(negedge clk);
      chk("R11 forced held", 0, 1, 0, 1);
      force_x1 = 0;
      #1 chk("R11 restored", 3, 1, 0, 1);

      stream(240, 2'b01, 1'b0, 1'b1, 1'b0); chk("R5 32b both", 3, 1, 0, 1);

      // R7: short stream
      stream(200, 2'b01, 1'b0, 1'b1, 1'b0); chk("R7 short stream", 0, 0, 1, 0);
      // R9: words after error ignored
      @(negedge clk);
      word_vld = 1; word_idx = 16'd229; word_data = 32'h0;
      @(negedge clk);
      word_vld = 0;
      @(negedge clk);
      chk("R9 hold after error", 0, 0, 1, 0);

      // R8: hdr_end together with word 229 (exactly 230 words)
      stream(230, 2'b01, 1'b1, 1'b0, 1'b1); chk("R8 end with word 229", 1, 1, 0, 0);

      // R6: timing of valid
      @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0; wide_sel = 1;
      word_vld = 1; word_idx = 16'd229; word_data = 32'h0;
      #1 chk("R6 not yet valid", 0, 0, 0, 0);
      @(posedge clk); #1;
      word_vld = 0;
      chk("R6 valid next cycle", 3, 1, 0, 1);

      // R10: start with word 229 in same cycle
      @(negedge clk);
      start = 1; word_vld = 1; word_idx = 16'd229; word_data = 32'h0;
      @(negedge clk);
      start = 0; word_vld = 0;
      chk("R10 start wins", 0, 0, 0, 0);

      // R12: word_vld low at index 229 is ignored
      word_idx = 16'd229; word_data = 32'h0; hdr_end = 0;
      repeat (3) @(negedge clk);
      chk("R12 invalid word ignored", 0, 0, 0, 0);

      idle();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule